// File: doc/BRIEF.md
# Memory-Mapped Quad Serial Flash Read Engine

This block answers word reads on a memory-mapped window by streaming data out of a serial flash over a four-line SPI link. A read arrives as a held request with an address. The engine keeps one flash transaction open for as long as the reads stay consecutive. While the transaction is open it prefetches words into a small receive FIFO, so a run of sequential reads is served from local storage with no new command.

A read at an address other than the expected next one closes the transaction. The chip select then stays inactive for a programmed number of system clocks, and a new transaction starts that carries the new address. The first read after reset is always handled this way. Stale prefetched words are discarded at every such jump.

While the FIFO holds data, the engine raises a DMA request on each implemented channel whose enable bit is set.

Top module: `qspi_xip_reader`

## Requirements
- R1: A read whose address differs from the expected next address, or the first read after reset, starts a new transaction. Chip select goes high in the cycle after the read is seen, the FIFO is emptied, and the returned word comes from the new address.
- R2: Between the end of one transaction and the start of the next, chip select stays high for exactly `cfg_gap`+1 system clocks. A value of 0 gives 1 clock, 15 gives 16 clocks, and the value after reset is 0.
- R3: Each transaction has four phases in this order. The read command `READ_CMD` (default 0xEB) goes out first, MSB first, on `qspi_io_o[0]` with output enable 4'b0001. The 24-bit address follows as six nibbles, most significant first, on all four lines. Then come `cfg_dummy` serial cycles with every output disabled. The data phase comes last. The serial clock idles low, runs at half the system clock, and the flash samples on its rising edge.
- R4: Read data arrives as nibbles, the high nibble of each byte first. The byte at the lowest address lands in `bus_rdata[7:0]` and the byte at address+3 lands in `bus_rdata[31:24]`.
- R5: A read at the expected next address (previous read address + 4) is served inside the open transaction. Chip select stays low and no command is sent.
- R6: `bus_ready` is a one-cycle pulse. It is raised only while a request is pending and the FIFO holds the requested word. Otherwise the read stalls with `bus_ready` low.
- R7: While a transaction is open, the engine prefetches until the FIFO holds `FIFO_DEPTH` words. It then stops the serial clock with chip select still low, so a read followed by idle fetches exactly `FIFO_DEPTH`+1 words.
- R8: `dma_req[i]` is high exactly when `cfg_dma_en[i]` is set and the FIFO is not empty, for i < `NUM_DMA`. Enable bits at or above `NUM_DMA` have no effect.
- R9: During reset, chip select is high, the serial clock is low, all outputs are disabled, `bus_ready` is low and `dma_req` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_gap | input | 4 | Chip-select inactive gap minus one, in system clocks |
| cfg_dummy | input | 4 | Dummy serial cycles before data |
| cfg_dma_en | input | 16 | Per-channel DMA request enable |
| bus_req | input | 1 | Read request, held until `bus_ready` |
| bus_addr | input | 24 | Word-aligned read address |
| bus_ready | output | 1 | One-cycle read completion pulse |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| dma_req | output | NUM_DMA | Per-channel DMA request |
| qspi_cs_n | output | 1 | Flash chip select, active low |
| qspi_sck | output | 1 | Serial clock |
| qspi_io_o | output | 4 | Serial data out |
| qspi_io_oe | output | 4 | Per-line output enable |
| qspi_io_i | input | 4 | Serial data in |

## Verification
The hardest state to reach is a jump that arrives while a transaction is paused with a full FIFO, or while a word is half assembled. This is also the only place where stale data or a short gap could leak out. The bench first lets a transaction prefetch until the serial clock stops, then sweeps all sixteen gap settings. Each setting is paired with a sequential read and a forward jump, and the dummy count changes from step to step. A behavioural flash model counts serial clock edges, returns an address-derived byte pattern, and measures every inactive gap in system clocks. A final backward jump into the already prefetched range checks that flushed words never come back.

// File: rtl/qxr_pkg.sv
// Shared types for the quad serial flash read engine.
// Assumes: one serial clock period spans two system clocks.
package qxr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GAP   = 3'd1,
        ST_CMD   = 3'd2,
        ST_ADDR  = 3'd3,
        ST_DUMMY = 3'd4,
        ST_DATA  = 3'd5
    } qxr_state_e;

    localparam int CMD_BITS = 8;
endpackage

// File: rtl/qxr_fifo.sv
// Receive FIFO for prefetched words.
// A flush empties it and overrides a push in the same cycle.
// Assumes the writer never pushes while full (checked below).
module qxr_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign head_o  = mem[rd_q];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop_i)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_i && !flush_i) mem[wr_q] <= data_i;
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !flush_i) |-> (!full_o || pop_i));
endmodule

// File: rtl/qxr_seq.sv
// Serial sequencer: chip-select gap, command, address, dummy and data
// phases. It assembles received nibbles into words and pushes them into
// the FIFO. A restart aborts any transaction in progress.
// Assumes the serial clock is the system clock divided by two.
module qxr_seq
    import qxr_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter int          WORD_W   = 32,
    parameter logic [7:0]  READ_CMD = 8'hEB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [3:0]        gap_i,
    input  logic [3:0]        dummy_i,
    input  logic              fifo_full_i,
    output logic              push_o,
    output logic [WORD_W-1:0] word_o,
    output logic              cs_n_o,
    output logic              sck_o,
    output logic [3:0]        io_o,
    output logic [3:0]        io_oe_o,
    input  logic [3:0]        io_i
);
    localparam int ADDR_NIBS = ADDR_W / 4;
    localparam int WORD_NIBS = WORD_W / 4;
    localparam int NW        = $clog2(WORD_NIBS);
    localparam int CNT_W     = 5;

    qxr_state_e          state_q;
    logic                ph_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [NW-1:0]       nib_q;
    logic [3:0]          gap_q, gapcnt_q, dummy_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [WORD_W-1:0]   word_q, word_nx;
    logic                last_nib, stall;

    assign last_nib = (nib_q == NW'(WORD_NIBS - 1));
    assign stall    = (state_q == ST_DATA) && !ph_q && (nib_q == '0) && fifo_full_i;
    assign cs_n_o   = (state_q == ST_IDLE) || (state_q == ST_GAP);
    assign sck_o    = ph_q;
    assign push_o   = (state_q == ST_DATA) && ph_q && last_nib && !restart_i;
    assign word_o   = word_nx;

    // Merge the nibble being sampled into the word under assembly.
    always_comb begin
        word_nx = word_q;
        word_nx[{nib_q >> 1, 3'b000} + (nib_q[0] ? 0 : 4) +: 4] = io_i;
    end

    // Drive the data lines for the command and address phases.
    always_comb begin
        io_o    = 4'h0;
        io_oe_o = 4'h0;
        if (state_q == ST_CMD) begin
            io_oe_o = 4'b0001;
            io_o[0] = READ_CMD[3'(CMD_BITS - 1 - int'(cnt_q))];
        end else if (state_q == ST_ADDR) begin
            io_oe_o = 4'b1111;
            io_o    = addr_q[(ADDR_NIBS - 1 - int'(cnt_q)) * 4 +: 4];
        end
    end

    // Phase state machine and serial clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ph_q     <= 1'b0;
            cnt_q    <= '0;
            nib_q    <= '0;
            gap_q    <= '0;
            gapcnt_q <= '0;
            dummy_q  <= '0;
            addr_q   <= '0;
            word_q   <= '0;
        end else if (restart_i) begin
            state_q  <= ST_GAP;
            ph_q     <= 1'b0;
            cnt_q    <= '0;
            nib_q    <= '0;
            gap_q    <= gap_i;
            gapcnt_q <= gap_i;
            dummy_q  <= dummy_i;
            addr_q   <= addr_i;
        end else if (state_q == ST_GAP) begin
            if (gapcnt_q == '0) state_q <= ST_CMD;
            else                gapcnt_q <= gapcnt_q - 1'b1;
        end else if (state_q != ST_IDLE) begin
            if (!ph_q) begin
                if (!stall) ph_q <= 1'b1;
            end else begin
                ph_q <= 1'b0;
                cnt_q <= cnt_q + 1'b1;
                case (state_q)
                    ST_CMD: if (cnt_q == CNT_W'(CMD_BITS - 1)) begin
                        state_q <= ST_ADDR;
                        cnt_q   <= '0;
                    end
                    ST_ADDR: if (cnt_q == CNT_W'(ADDR_NIBS - 1)) begin
                        state_q <= (dummy_q == '0) ? ST_DATA : ST_DUMMY;
                        cnt_q   <= '0;
                    end
                    ST_DUMMY: if (cnt_q == CNT_W'(dummy_q - 4'd1)) begin
                        state_q <= ST_DATA;
                        cnt_q   <= '0;
                    end
                    default: begin
                        cnt_q  <= '0;
                        word_q <= word_nx;
                        nib_q  <= last_nib ? '0 : nib_q + 1'b1;
                    end
                endcase
            end
        end
    end

    // Checker: consecutive chip-select-high cycles since the last restart.
    logic [5:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) hi_run_q <= '0;
        else if (cs_n_o)         hi_run_q <= (hi_run_q == 6'h3F) ? hi_run_q : hi_run_q + 1'b1;
        else                     hi_run_q <= '0;
    end

    a_r2_gap_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (hi_run_q == 6'(gap_q) + 6'd1));
    a_r3_quiet_in_dummy: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && sck_o && io_oe_o == 4'h0) |-> (state_q == ST_DUMMY || state_q == ST_DATA));
endmodule

// File: rtl/qxr_dma_mask.sv
// Per-channel DMA request gating. Only the first NUM_DMA enable bits
// reach a channel; the rest of the mask is ignored.
module qxr_dma_mask #(
    parameter int NUM_DMA = 4,
    parameter int MASK_W  = 16
) (
    input  logic               ready_i,
    input  logic [MASK_W-1:0]  en_i,
    output logic [NUM_DMA-1:0] req_o
);
    // One gate per implemented channel.
    for (genvar i = 0; i < NUM_DMA; i++) begin : g_ch
        assign req_o[i] = ready_i & en_i[i];
    end

    if (MASK_W > NUM_DMA) begin : g_spare
        logic unused_hi;
        assign unused_hi = ^en_i[MASK_W-1:NUM_DMA];
    end
endmodule

// File: rtl/qspi_xip_reader.sv
// Memory-mapped read engine for a quad serial flash.
// It serves word reads from a prefetch FIFO, keeps the transaction open
// across consecutive addresses, and restarts on any other address.
// Assumes word-aligned addresses, and a bus master that holds its request
// and address until bus_ready.
module qspi_xip_reader #(
    parameter int         ADDR_W     = 24,
    parameter int         DATA_W     = 32,
    parameter int         FIFO_DEPTH = 4,
    parameter int         NUM_DMA    = 4,
    parameter int         MASK_W     = 16,
    parameter logic [7:0] READ_CMD   = 8'hEB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         cfg_gap,
    input  logic [3:0]         cfg_dummy,
    input  logic [MASK_W-1:0]  cfg_dma_en,
    input  logic               bus_req,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_ready,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_DMA-1:0] dma_req,
    output logic               qspi_cs_n,
    output logic               qspi_sck,
    output logic [3:0]         qspi_io_o,
    output logic [3:0]         qspi_io_oe,
    input  logic [3:0]         qspi_io_i
);
    localparam int BYTES = DATA_W / 8;

    logic              sess_q, ready_q;
    logic [ADDR_W-1:0] next_q;
    logic [DATA_W-1:0] rdata_q, head, push_word;
    logic              hit, restart, pop, push, full, empty;

    assign hit     = sess_q && (bus_addr == next_q);
    assign restart = bus_req && !ready_q && !hit;
    assign pop     = bus_req && !ready_q && hit && !empty;

    assign bus_ready = ready_q;
    assign bus_rdata = rdata_q;

    // Session flag, next-address tracking and the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sess_q  <= 1'b0;
            next_q  <= '0;
            ready_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            ready_q <= pop;
            if (pop) begin
                rdata_q <= head;
                next_q  <= next_q + ADDR_W'(BYTES);
            end
            if (restart) begin
                sess_q <= 1'b1;
                next_q <= bus_addr;
            end
        end
    end

    qxr_seq #(.ADDR_W(ADDR_W), .WORD_W(DATA_W), .READ_CMD(READ_CMD)) seq_i (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .addr_i(bus_addr),
        .gap_i(cfg_gap), .dummy_i(cfg_dummy), .fifo_full_i(full),
        .push_o(push), .word_o(push_word), .cs_n_o(qspi_cs_n), .sck_o(qspi_sck),
        .io_o(qspi_io_o), .io_oe_o(qspi_io_oe), .io_i(qspi_io_i)
    );

    qxr_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .flush_i(restart), .push_i(push),
        .data_i(push_word), .pop_i(pop), .head_o(head), .full_o(full), .empty_o(empty)
    );

    qxr_dma_mask #(.NUM_DMA(NUM_DMA), .MASK_W(MASK_W)) dma_i (
        .ready_i(!empty), .en_i(cfg_dma_en), .req_o(dma_req)
    );

    a_r1_cs_high_on_jump: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> qspi_cs_n);
    a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);
    a_r6_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ready) |-> $past(bus_req));
    a_r8_dma_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req & ~cfg_dma_en[NUM_DMA-1:0]) == '0);
endmodule

// File: tb/qspi_xip_reader_tb_top.sv
module qspi_xip_reader_tb_top;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  cfg_gap, cfg_dummy;
    logic [15:0] cfg_dma_en;
    logic        bus_req;
    logic [23:0] bus_addr;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic [3:0]  dma_req;
    logic        qspi_cs_n, qspi_sck;
    logic [3:0]  qspi_io_o, qspi_io_oe, qspi_io_i;

    int vectors = 0, fails = 0, cycles = 0;

    always #5 clk = ~clk;

    qspi_xip_reader dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_gap(cfg_gap), .cfg_dummy(cfg_dummy),
        .cfg_dma_en(cfg_dma_en), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .dma_req(dma_req),
        .qspi_cs_n(qspi_cs_n), .qspi_sck(qspi_sck), .qspi_io_o(qspi_io_o),
        .qspi_io_oe(qspi_io_oe), .qspi_io_i(qspi_io_i)
    );

    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
    endfunction

    function automatic logic [31:0] fword(input logic [23:0] a);
        return {fbyte(a + 24'd3), fbyte(a + 24'd2), fbyte(a + 24'd1), fbyte(a)};
    endfunction

    // Flash model state, updated at the falling system clock edge.
    int          txn_count = 0, hi_run = 0, last_gap = 0, pcnt = 0, m_dummy = 0, data_nibs = 0;
    logic [7:0]  m_cmd = '0;
    logic [23:0] m_addr = '0;
    logic        prev_cs = 1'b1, prev_sck = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            txn_count = 0; hi_run = 0; prev_cs = 1'b1; prev_sck = 1'b0; pcnt = 0;
        end else begin
            if (qspi_cs_n) hi_run++;
            else begin
                if (prev_cs) begin
                    txn_count++; last_gap = hi_run; hi_run = 0; pcnt = 0;
                    m_cmd = '0; m_addr = '0; m_dummy = int'(cfg_dummy); data_nibs = 0;
                end
                if (qspi_sck && !prev_sck) begin
                    pcnt++;
                    if (pcnt <= 8)                m_cmd  = {m_cmd[6:0], qspi_io_o[0]};
                    else if (pcnt <= 14)          m_addr = {m_addr[19:0], qspi_io_o};
                    else if (pcnt > 14 + m_dummy) data_nibs++;
                end
            end
            prev_cs = qspi_cs_n; prev_sck = qspi_sck;
        end
    end

    function automatic logic [3:0] fnib(input logic [23:0] a, input int k);
        logic [7:0] b;
        b = fbyte(a + 24'(k / 2));
        return (k % 2 == 0) ? b[7:4] : b[3:0];
    endfunction

    assign qspi_io_i = (!qspi_cs_n && pcnt > 14 + m_dummy) ? fnib(m_addr, pcnt - 15 - m_dummy) : 4'h0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [23:0] a, output logic [31:0] d);
        bit got = 0;
        bus_req = 1'b1; bus_addr = a;
        for (int i = 0; i < 3000 && !got; i++) begin
            @(negedge clk); #1;
            if (bus_ready) got = 1;
        end
        d = bus_rdata;
        bus_req = 1'b0;
        chk(got, "R6 read completes", 32'(got), 1);
        @(negedge clk); #1;
        chk(!bus_ready, "R6 ready is one cycle", 32'(bus_ready), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [23:0] a0;
        int t;
        rst_n = 1'b0; cfg_gap = '0; cfg_dummy = '0; cfg_dma_en = 16'hFFFF;
        bus_req = 1'b0; bus_addr = '0;
        repeat (4) @(negedge clk);
        #1;
        // R9 reset state
        chk(qspi_cs_n == 1'b1, "R9 cs_n", 32'(qspi_cs_n), 1);
        chk(qspi_sck == 1'b0, "R9 sck", 32'(qspi_sck), 0);
        chk(qspi_io_oe == 4'h0, "R9 oe", 32'(qspi_io_oe), 0);
        chk(bus_ready == 1'b0, "R9 ready", 32'(bus_ready), 0);
        chk(dma_req == 4'h0, "R9 dma_req", 32'(dma_req), 0);
        rst_n = 1'b1; cfg_dma_en = '0;
        @(negedge clk); #1;

        // Gap sweep with sequential and jump reads (R1..R5)
        for (int g = 0; g < 16; g++) begin
            cfg_gap = 4'(g);
            cfg_dummy = 4'((g * 5) % 9);
            a0 = 24'h010000 + 24'(g * 'h1230);
            a0[1:0] = 2'b00;
            t = txn_count;
            rd(a0, d);
            chk(d == fword(a0), "R4 first word", d, fword(a0));
            chk(txn_count == t + 1, "R1 non-sequential opens transaction", 32'(txn_count), 32'(t + 1));
            chk(m_cmd == 8'hEB, "R3 command byte", 32'(m_cmd), 32'hEB);
            chk(m_addr == a0, "R3 address", 32'(m_addr), 32'(a0));
            rd(a0 + 24'd4, d);
            chk(d == fword(a0 + 24'd4), "R5 sequential word", d, fword(a0 + 24'd4));
            chk(txn_count == t + 1, "R5 no new transaction", 32'(txn_count), 32'(t + 1));
            rd(a0 + 24'h40, d);
            chk(d == fword(a0 + 24'h40), "R1 jump word", d, fword(a0 + 24'h40));
            chk(txn_count == t + 2, "R1 jump restarts", 32'(txn_count), 32'(t + 2));
            chk(last_gap == g + 1, "R2 gap length", 32'(last_gap), 32'(g + 1));
            chk(m_addr == a0 + 24'h40, "R3 jump address", 32'(m_addr), 32'(a0 + 24'h40));
        end

        // Prefetch depth (R7)
        cfg_dummy = 4'd2; cfg_gap = 4'd3;
        rd(24'h200000, d);
        chk(d == fword(24'h200000), "R4 prefetch base", d, fword(24'h200000));
        repeat (400) @(negedge clk);
        #1;
        chk(data_nibs == 8 * (DEPTH + 1), "R7 prefetch stops when full", 32'(data_nibs), 32'(8 * (DEPTH + 1)));
        chk(qspi_cs_n == 1'b0, "R7 cs held while paused", 32'(qspi_cs_n), 0);
        chk(qspi_sck == 1'b0, "R7 sck parked low", 32'(qspi_sck), 0);

        // DMA mask sweep with FIFO non-empty (R8)
        for (int e = 0; e < 16; e++) begin
            cfg_dma_en = 16'(e) | (16'hFFF0 ^ 16'(e << 4));
            @(negedge clk); #1;
            chk(dma_req == 4'(e), "R8 dma mask", 32'(dma_req), 32'(e));
        end
        cfg_dma_en = 16'hFFF0;
        @(negedge clk); #1;
        chk(dma_req == 4'h0, "R8 upper bits ignored", 32'(dma_req), 0);
        cfg_dma_en = 16'h000F;

        // Long sequential run across FIFO refills (R5, R7)
        t = txn_count;
        for (int i = 1; i <= 12; i++) begin
            rd(24'h200000 + 24'(4 * i), d);
            chk(d == fword(24'h200000 + 24'(4 * i)), "R7 streamed word", d, fword(24'h200000 + 24'(4 * i)));
        end
        chk(txn_count == t, "R5 run kept one transaction", 32'(txn_count), 32'(t));

        // Backward jump into prefetched range: flushed data must not return (R1)
        rd(24'h200008, d);
        chk(d == fword(24'h200008), "R1 backward jump word", d, fword(24'h200008));
        chk(txn_count == t + 1, "R1 backward jump restarts", 32'(txn_count), 32'(t + 1));
        chk(last_gap == 4, "R2 gap after flush", 32'(last_gap), 4);
        repeat (300) @(negedge clk);
        #1;
        chk(dma_req == 4'hF, "R8 requests after refill", 32'(dma_req), 32'hF);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule